// File: doc/BRIEF.md
# Peripheral Clock Gate and Block Reset Controller

This block owns the clock-gate enables and the block-reset lines of twenty peripheral consumers. The consumers are spread over three domains: the main interconnect, a fast peripheral bridge and a slow peripheral bridge. Each domain has four 16-bit registers, reached through a plain register port with a single write strobe and a combinational read. Software turns clocks on by writing a one-hot or multi-bit mask to a set register. It turns them off by writing a mask to a separate clear register, so it never needs a read-modify-write. A status register shows which clocks are running, and a reset register holds blocks in reset or releases them.

Not every consumer is software-gated. Hardware-controlled clocks follow a per-consumer request input and ignore software. Always-on clocks cannot be switched at all. One consumer has no enable bit of its own. The status bit and the reset bit of a consumer are chosen separately, because they are not always at the same position. The gate-enable outputs come straight from flops, so a downstream latch-based clock gate sees a clean level. The port carries no data stream, so it has no valid/ready handshake: a write takes effect at the clock edge on which the strobe is sampled, and a read is never stalled.

Top module: `cerc_ctrl`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, every `blk_rst` bit is 1, every software-gated and hardware-controlled gate is 0, and the reset registers read 0x1778, 0x0067 and 0x01F3 for domains 0, 1 and 2. Status registers read 0x1000, 0x0000 and 0x0000, and `gate_en` is 0x20040.
- R2: The set register is at register code 1. A write to it turns on every software-gated clock of that domain whose status bit is 1 in the mask. Zero bits leave clocks unchanged. The new value appears at the ports from the capturing edge on.
- R3: The clear register is at register code 2. A write to it turns off every software-gated clock of that domain whose status bit is 1 in the mask. Zero bits leave clocks unchanged.
- R4: `reg_addr` = {domain[1:0], register[1:0]}. Domain 0 is the interconnect, 1 the fast bridge and 2 the slow bridge. The status register is register code 0. A status bit is 1 exactly when its consumer's clock runs, and `gate_en[k]` equals that bit.
- R5: The consumer table lists, for each index k, the domain, the reset bit, the status bit and the kind:
  - 0: domain 0, reset 3, status 3, hardware
  - 1: domain 0, reset 4, status 4, hardware
  - 2: domain 0, reset 6, status 6, software
  - 3: domain 0, reset 8, status 8, hardware
  - 4: domain 0, reset 9, status 9, software
  - 5: domain 0, reset 10, status 10, hardware
  - 6: domain 0, reset 12, status 12, always-on
  - 7: domain 0, reset 5, status 5, software
  - 8: domain 1, reset 0, status 0, hardware
  - 9: domain 1, reset 1, status 1, software
  - 10: domain 1, reset 2, status 2, software
  - 11: domain 1, reset 5, status 5, software
  - 12: domain 1, reset 6, status 6, software
  - 13: domain 2, reset 0, status 0, hardware
  - 14: domain 2, reset 1, status 1, software
  - 15: domain 2, reset 4, status 4, software
  - 16: domain 2, reset 5, status 6, software
  - 17: domain 2, reset 6, no status bit, always-on
  - 18: domain 2, reset 7, status 7, software
  - 19: domain 2, reset 8, status 8, software
- R6: The reset register is at register code 3 and is read/write. A 1 holds the consumer in reset (`blk_rst[k]`=1) and a 0 releases it. Bits that no consumer uses as a reset bit ignore writes and read 0.
- R7: Consumer 16 takes its reset from bit 5 and its gate from bit 6 of domain 2. Bit 5 of the domain 2 set register has no effect on any gate.
- R8: Always-on consumers 6 and 17 keep `gate_en` at 1 through any write. Domain 0 status bit 12 always reads 1.
- R9: Hardware-controlled consumers ignore set and clear writes. Their gate equals `hw_req[k]` as sampled at the previous clock edge. `hw_req` bits of all other consumers are ignored.
- R10: `gate_en` changes only at a rising clock edge, one edge after the write or request that causes the change.
- R11: A clock that is enabled while its consumer is held in reset shows 1 in status and on `gate_en`, while `blk_rst` stays 1.
- R12: Set and clear registers read 0. Domain code 3 reads 0, and writes to it have no effect. Status bits with no gated consumer read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr | input | 4 | {domain, register code} |
| reg_wdata | input | 16 | Write mask or reset value |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| hw_req | input | 20 | Per-consumer run request for hardware-controlled clocks |
| gate_en | output | 20 | Per-consumer clock-gate enable |
| blk_rst | output | 20 | Per-consumer block reset, 1 = held |

## Verification
A software write and a change of a hardware run request can land on the same clock edge. This block must then let the request win for hardware-controlled bits while applying the mask to software bits in the same domain. The bench provokes this by raising the request of consumer 1 in the cycle that a clear mask covers both its bit and the bit of software consumer 2. It then drops the request while a set mask names the same bit. In each case it judges `gate_en` one edge later. A second collision drives a request and a write to another domain in one cycle, and samples `gate_en` before and after the edge to confirm that neither change leaks through early.

// File: rtl/cerc_pkg.sv
package cerc_pkg;
  localparam int REG_W    = 16;
  localparam int NUM_DOM  = 3;
  localparam int NUM_CONS = 20;
  localparam int SEL_W    = 2;
  localparam int DOM_W    = 2;
  localparam int ADDR_W   = DOM_W + SEL_W;
  localparam int IDX_W    = $clog2(REG_W);

  typedef enum logic [1:0] {GK_SW = 2'd0, GK_HW = 2'd1, GK_ON = 2'd2} gate_kind_e;

  typedef enum logic [SEL_W-1:0] {
    RS_STATUS = 2'd0,
    RS_ON     = 2'd1,
    RS_OFF    = 2'd2,
    RS_HOLD   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [DOM_W-1:0] dom;
    logic [IDX_W-1:0] rst_idx;
    logic [IDX_W-1:0] gate_idx;
    logic             has_gate;
    gate_kind_e       kind;
  } cons_desc_t;

  function automatic cons_desc_t mk(int d, int r, int g, bit hg, gate_kind_e kd);
    cons_desc_t c;
    c.dom      = DOM_W'(d);
    c.rst_idx  = IDX_W'(r);
    c.gate_idx = IDX_W'(g);
    c.has_gate = hg;
    c.kind     = kd;
    return c;
  endfunction

  // Consumer table: domain, reset bit, gate/status bit, has gate, kind.
  function automatic cons_desc_t cons_desc(int k);
    case (k)
      0:  return mk(0, 3, 3, 1'b1, GK_HW);
      1:  return mk(0, 4, 4, 1'b1, GK_HW);
      2:  return mk(0, 6, 6, 1'b1, GK_SW);
      3:  return mk(0, 8, 8, 1'b1, GK_HW);
      4:  return mk(0, 9, 9, 1'b1, GK_SW);
      5:  return mk(0, 10, 10, 1'b1, GK_HW);
      6:  return mk(0, 12, 12, 1'b1, GK_ON);
      7:  return mk(0, 5, 5, 1'b1, GK_SW);
      8:  return mk(1, 0, 0, 1'b1, GK_HW);
      9:  return mk(1, 1, 1, 1'b1, GK_SW);
      10: return mk(1, 2, 2, 1'b1, GK_SW);
      11: return mk(1, 5, 5, 1'b1, GK_SW);
      12: return mk(1, 6, 6, 1'b1, GK_SW);
      13: return mk(2, 0, 0, 1'b1, GK_HW);
      14: return mk(2, 1, 1, 1'b1, GK_SW);
      15: return mk(2, 4, 4, 1'b1, GK_SW);
      16: return mk(2, 5, 6, 1'b1, GK_SW);
      17: return mk(2, 6, 0, 1'b0, GK_ON);
      18: return mk(2, 7, 7, 1'b1, GK_SW);
      19: return mk(2, 8, 8, 1'b1, GK_SW);
      default: return mk(3, 0, 0, 1'b0, GK_ON);
    endcase
  endfunction

  function automatic logic [REG_W-1:0] gate_mask(int d, gate_kind_e kd);
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_CONS; k++) begin
      if (int'(cons_desc(k).dom) == d && cons_desc(k).has_gate && cons_desc(k).kind == kd)
        m[cons_desc(k).gate_idx] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [REG_W-1:0] hold_mask(int d);
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_CONS; k++) begin
      if (int'(cons_desc(k).dom) == d)
        m[cons_desc(k).rst_idx] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/cerc_addr_dec.sv
module cerc_addr_dec
  import cerc_pkg::*;
#(
  parameter int ND = NUM_DOM
) (
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [ND-1:0]     wr_on,
  output logic [ND-1:0]     wr_off,
  output logic [ND-1:0]     wr_hold,
  output logic              dom_valid,
  output logic [DOM_W-1:0]  dom_idx,
  output reg_sel_e          sel
);
  always_comb begin
    dom_idx   = reg_addr[ADDR_W-1:SEL_W];
    sel       = reg_sel_e'(reg_addr[SEL_W-1:0]);
    dom_valid = int'(dom_idx) < ND;
    for (int d = 0; d < ND; d++) begin
      wr_on[d]   = reg_we && dom_valid && int'(dom_idx) == d && sel == RS_ON;
      wr_off[d]  = reg_we && dom_valid && int'(dom_idx) == d && sel == RS_OFF;
      wr_hold[d] = reg_we && dom_valid && int'(dom_idx) == d && sel == RS_HOLD;
    end
  end
endmodule

// File: rtl/cerc_bank.sv
module cerc_bank
  import cerc_pkg::*;
#(
  parameter int DOM = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_on,
  input  logic             wr_off,
  input  logic             wr_hold,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] hw_vec,
  output logic [REG_W-1:0] status,
  output logic [REG_W-1:0] hold
);
  localparam logic [REG_W-1:0] SW_M   = gate_mask(DOM, GK_SW);
  localparam logic [REG_W-1:0] HW_M   = gate_mask(DOM, GK_HW);
  localparam logic [REG_W-1:0] ON_M   = gate_mask(DOM, GK_ON);
  localparam logic [REG_W-1:0] HOLD_M = hold_mask(DOM);

  logic [REG_W-1:0] sw_q, hw_q, hold_q;

  // Every gate bit is one flop or a constant: no logic between flop and pin.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= '0;
      hw_q   <= '0;
      hold_q <= HOLD_M;
    end else begin
      hw_q <= hw_vec & HW_M;
      if (wr_on)
        sw_q <= sw_q | (wdata & SW_M);
      else if (wr_off)
        sw_q <= sw_q & ~(wdata & SW_M);
      if (wr_hold)
        hold_q <= wdata & HOLD_M;
    end
  end

  assign status = sw_q | hw_q | ON_M;
  assign hold   = hold_q;
endmodule

// File: rtl/cerc_ctrl.sv
module cerc_ctrl
  import cerc_pkg::*;
#(
  parameter int NCONS = NUM_CONS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NCONS-1:0]  hw_req,
  output logic [NCONS-1:0]  gate_en,
  output logic [NCONS-1:0]  blk_rst
);
  logic [NUM_DOM-1:0] wr_on, wr_off, wr_hold;
  logic               dom_valid;
  logic [DOM_W-1:0]   dom_idx;
  reg_sel_e           sel;
  logic [REG_W-1:0]   status [NUM_DOM];
  logic [REG_W-1:0]   hold   [NUM_DOM];
  logic [REG_W-1:0]   hw_vec [NUM_DOM];

  cerc_addr_dec #(.ND(NUM_DOM)) u_dec (
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .wr_on     (wr_on),
    .wr_off    (wr_off),
    .wr_hold   (wr_hold),
    .dom_valid (dom_valid),
    .dom_idx   (dom_idx),
    .sel       (sel)
  );

  // Route each hardware-controlled request onto its domain's gate bit.
  always_comb begin
    for (int d = 0; d < NUM_DOM; d++) hw_vec[d] = '0;
    for (int k = 0; k < NCONS; k++) begin
      if (cons_desc(k).kind == GK_HW && cons_desc(k).has_gate)
        hw_vec[cons_desc(k).dom][cons_desc(k).gate_idx] = hw_req[k];
    end
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    cerc_bank #(.DOM(d)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_on   (wr_on[d]),
      .wr_off  (wr_off[d]),
      .wr_hold (wr_hold[d]),
      .wdata   (reg_wdata),
      .hw_vec  (hw_vec[d]),
      .status  (status[d]),
      .hold    (hold[d])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (dom_valid) begin
      case (sel)
        RS_STATUS: reg_rdata = status[dom_idx];
        RS_HOLD:   reg_rdata = hold[dom_idx];
        default:   reg_rdata = '0;
      endcase
    end
  end

  for (genvar k = 0; k < NCONS; k++) begin : g_cons
    localparam cons_desc_t C = cons_desc(k);
    if (C.has_gate) begin : g_gated
      assign gate_en[k] = status[C.dom][C.gate_idx];
    end else begin : g_free
      assign gate_en[k] = 1'b1;
    end
    assign blk_rst[k] = hold[C.dom][C.rst_idx];
  end
endmodule

// File: rtl/cerc_ctrl_checker.sv
module cerc_ctrl_checker
  import cerc_pkg::*;
#(
  parameter int NCONS = NUM_CONS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [NCONS-1:0]  hw_req,
  input logic [NCONS-1:0]  gate_en,
  input logic [NCONS-1:0]  blk_rst
);
  assert_reset_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (&blk_rst));

  for (genvar k = 0; k < NCONS; k++) begin : g_chk
    localparam cons_desc_t C = cons_desc(k);
    localparam logic [ADDR_W-1:0] A_ST = {C.dom, RS_STATUS};
    localparam logic [ADDR_W-1:0] A_ON = {C.dom, RS_ON};
    localparam logic [ADDR_W-1:0] A_OF = {C.dom, RS_OFF};
    localparam logic [ADDR_W-1:0] A_HD = {C.dom, RS_HOLD};

    assert_hold_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_HD) |=> (blk_rst[k] == $past(reg_wdata[C.rst_idx])));

    if (C.has_gate) begin : g_st
      assert_status_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_ST) |-> (reg_rdata[C.gate_idx] == gate_en[k]));
    end

    if (C.kind == GK_SW) begin : g_sw
      assert_set_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_ON && reg_wdata[C.gate_idx]) |=> gate_en[k]);
      assert_clear_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_OF && reg_wdata[C.gate_idx]) |=> !gate_en[k]);
      assert_quiet_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(gate_en[k]));
    end

    if (C.kind == GK_HW) begin : g_hw
      assert_hw_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (gate_en[k] == $past(hw_req[k])));
    end

    if (C.kind == GK_ON) begin : g_on
      assert_always_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> gate_en[k]);
    end
  end
endmodule

bind cerc_ctrl cerc_ctrl_checker #(.NCONS(NCONS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .hw_req    (hw_req),
  .gate_en   (gate_en),
  .blk_rst   (blk_rst)
);

// File: tb/cerc_ctrl_bench.sv
`timescale 1ns/1ps
module cerc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [19:0] hw_req = '0;
  logic [19:0] gate_en;
  logic [19:0] blk_rst;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [19:0] GATE_RST = 20'h20040;

  always #2.5 clk = ~clk;

  cerc_ctrl u_cerc_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
    .gate_en(gate_en), .blk_rst(blk_rst)
  );

  function automatic logic [3:0] ad(int d, int s);
    return {2'(d), 2'(s)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_we = 1'b0; hw_req = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 blk_rst", blk_rst, 20'hFFFFF);
    chk("R1 gate_en", gate_en, GATE_RST);
    rd_chk("R1 hold d0", ad(0, 3), 16'h1778);
    rd_chk("R1 hold d1", ad(1, 3), 16'h0067);
    rd_chk("R1 hold d2", ad(2, 3), 16'h01F3);
    rd_chk("R1 status d0", ad(0, 0), 16'h1000);
    rd_chk("R1 status d1", ad(1, 0), 16'h0000);
    rd_chk("R1 status d2", ad(2, 0), 16'h0000);
  endtask

  task automatic t_set_clear();
    do_reset();
    wr(ad(1, 1), 16'h0006);
    chk("R2 set two", gate_en, GATE_RST | 20'h00600);
    wr(ad(1, 1), 16'h0020);
    chk("R2 zero bits keep", gate_en, GATE_RST | 20'h00E00);
    rd_chk("R4 status d1", ad(1, 0), 16'h0026);
    wr(ad(1, 2), 16'h0002);
    chk("R3 clear one", gate_en, GATE_RST | 20'h00C00);
    wr(ad(1, 2), 16'h0000);
    chk("R3 empty mask", gate_en, GATE_RST | 20'h00C00);
    rd_chk("R4 status after clear", ad(1, 0), 16'h0024);
  endtask

  task automatic t_hold_reg();
    do_reset();
    wr(ad(0, 3), 16'h0000);
    chk("R6 release d0", blk_rst, 20'hFFF00);
    rd_chk("R6 readback zero", ad(0, 3), 16'h0000);
    wr(ad(0, 3), 16'hFFFF);
    rd_chk("R6 unused bits read 0", ad(0, 3), 16'h1778);
    chk("R6 hold all", blk_rst, 20'hFFFFF);
    wr(ad(0, 3), 16'h0040);
    chk("R5 bit6 holds consumer 2", blk_rst, 20'hFFF04);
  endtask

  task automatic t_split_index();
    do_reset();
    wr(ad(2, 3), 16'h01D3);
    chk("R7 reset bit5 frees 16", blk_rst, 20'hEFFFF);
    wr(ad(2, 1), 16'h0020);
    chk("R7 set bit5 no gate", gate_en, GATE_RST);
    wr(ad(2, 1), 16'h0040);
    chk("R7 set bit6 gates 16", gate_en, GATE_RST | 20'h10000);
    rd_chk("R7 status d2", ad(2, 0), 16'h0040);
    chk("R7 reset unchanged", blk_rst, 20'hEFFFF);
  endtask

  task automatic t_always_on();
    do_reset();
    wr(ad(0, 2), 16'h1000);
    chk("R8 clear ignored", gate_en, GATE_RST);
    rd_chk("R8 status bit12", ad(0, 0), 16'h1000);
    wr(ad(0, 1), 16'hFFFF);
    chk("R2 set all d0", gate_en, GATE_RST | 20'h00094);
    wr(ad(0, 2), 16'hFFFF);
    chk("R8 clear all d0", gate_en, GATE_RST);
  endtask

  task automatic t_hw_ctrl();
    do_reset();
    wr(ad(0, 1), 16'h0518);
    chk("R9 set ignored", gate_en, GATE_RST);
    hw_req[0] = 1'b1;
    hw_req[2] = 1'b1;
    @(negedge clk);
    chk("R9 request on", gate_en, GATE_RST | 20'h00001);
    rd_chk("R9 status d0", ad(0, 0), 16'h1008);
    wr(ad(0, 2), 16'h0008);
    chk("R9 clear ignored", gate_en, GATE_RST | 20'h00001);
    hw_req[0] = 1'b0;
    @(negedge clk);
    chk("R9 request off", gate_en, GATE_RST);
    hw_req = '0;
  endtask

  task automatic t_collide();
    do_reset();
    wr(ad(0, 1), 16'h0040);
    chk("R2 prep", gate_en, GATE_RST | 20'h00004);
    hw_req[1] = 1'b1;
    wr(ad(0, 2), 16'h0050);
    chk("R9 R3 same edge", gate_en, GATE_RST | 20'h00002);
    hw_req[1] = 1'b0;
    wr(ad(0, 1), 16'h0010);
    chk("R9 R2 same edge", gate_en, GATE_RST);
  endtask

  task automatic t_edge_only();
    do_reset();
    hw_req[5] = 1'b1;
    reg_we = 1'b1; reg_addr = ad(1, 1); reg_wdata = 16'h0040;
    #1;
    chk("R10 before edge", gate_en, GATE_RST);
    @(posedge clk);
    #1;
    chk("R10 after edge", gate_en, GATE_RST | 20'h01020);
    @(negedge clk);
    reg_we = 1'b0;
    hw_req = '0;
    @(negedge clk);
  endtask

  task automatic t_enabled_held();
    do_reset();
    wr(ad(2, 1), 16'h0080);
    chk("R11 gate on", gate_en, GATE_RST | 20'h40000);
    chk("R11 still held", blk_rst, 20'hFFFFF);
    rd_chk("R11 status", ad(2, 0), 16'h0080);
  endtask

  task automatic t_map();
    do_reset();
    wr(ad(2, 1), 16'hFFFF);
    rd_chk("R12 unused status bits", ad(2, 0), 16'h01D2);
    chk("R12 gates d2", gate_en, GATE_RST | 20'hDC000);
    rd_chk("R12 set reads 0", ad(2, 1), 16'h0000);
    rd_chk("R12 clear reads 0", ad(2, 2), 16'h0000);
    wr(ad(3, 3), 16'h0000);
    wr(ad(3, 1), 16'hFFFF);
    rd_chk("R12 dom3 reads 0", ad(3, 0), 16'h0000);
    rd_chk("R12 dom3 hold reads 0", ad(3, 3), 16'h0000);
    chk("R12 dom3 write no gate effect", gate_en, GATE_RST | 20'hDC000);
    chk("R12 dom3 write no reset effect", blk_rst, 20'hFFFFF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset_state();
    t_set_clear();
    t_hold_reg();
    t_split_index();
    t_always_on();
    t_hw_ctrl();
    t_collide();
    t_edge_only();
    t_enabled_held();
    t_map();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
    finish_run();
  end
endmodule